// File: doc/BRIEF.md
# APB Register Bank with Registered Ready

This block is an APB completer that holds a parameterised bank of 32-bit control registers (forty by default) inside a 256-byte window. The window sits at a fixed base value in the upper address byte. The ready output is built only from flops. A select flop remembers whether the previous edge saw a selected access inside the window. A second flop samples an external region-ready input. The ready output is then a single two-input mux between that sampled term and a constant one, so no address compare sits in its path.

Read data comes from a flopped mux output. The data register loads on every edge where the bus is selected and in its access phase, and it holds its value otherwise. A requester that lets at least the completing edge pass therefore sees the addressed register's contents once the transfer is done. Writes commit only on the completing edge, and only for mapped word offsets inside the window.

Top module: `apb_reg_bank`

## Requirements
- R1: While the active-low reset is asserted, and directly after it is released, the ready output is 1, the read data is zero, and every register holds zero.
- R2: After a rising edge where select is high and address bits [15:8] equal the base value, the ready output equals the region-ready input as it was sampled at that edge.
- R3: After a rising edge where select is low, or where address bits [15:8] differ from the base value, the ready output is 1.
- R4: Whenever select and enable are both high, the ready output is never unknown.
- R5: A completion edge (select, enable and ready all high) for an address inside the window only happens when the registered ready term is set.
- R6: The read-data output is loaded on every rising edge where select and enable are both high, and it stays unchanged on every other edge.
- R7: The loaded value is the register at word index address[7:2] when the address is inside the window and that index is below the register count. Otherwise the loaded value is zero, and address bits [1:0] are ignored.
- R8: A register takes the write data on an edge where select, enable, write and ready are all high and the address maps to it. An access-phase edge with ready low writes nothing.
- R9: A write to an unmapped index inside the window, or to any address outside the window, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock, rising edge active |
| busRstN | input | 1 | Asynchronous active-low reset |
| selIn | input | 1 | Completer select |
| enableIn | input | 1 | Access-phase marker |
| writeIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | 16 | Byte address; [15:8] window, [7:2] word index |
| wdataIn | input | 32 | Write data |
| regionReady | input | 1 | Addressed data is valid |
| rdataOut | output | 32 | Registered read data |
| readyOut | output | 1 | Transfer completion, one mux level off flops |

## Verification
A wrong select or ready flop shows at the ready output in the cycle right after the edge that loaded it. That makes an access complete early, stall, or fail to complete outside the window. A wrong register or mux entry stays hidden until that index is read back. It then shows in read data one edge after the completing edge. For this reason the bench writes every index of the window, reads every index back, and orders the reads so that consecutive addresses flip many address bits. Writes that should be ignored are checked by reading back the affected register afterwards.

// File: rtl/apb_bank_pkg.sv
package apb_bank_pkg;

  // word index comes from address bits [7:2]
  localparam int WORD_IDX_W = 6;

  typedef struct packed {
    logic                  wrEn;     // commit write data into wordIdx
    logic                  rdLoad;   // load read-data register
    logic                  inWindow; // address upper byte matches base
    logic [WORD_IDX_W-1:0] wordIdx;  // addressed word
  } bankStrobes_t;

endpackage

// File: rtl/apb_bank_ctrl.sv
module apb_bank_ctrl
  import apb_bank_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] BASE   = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              enableIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              regionReady,
  output logic              readyOut,
  output logic              readyQ,
  output bankStrobes_t      strobes
);

  localparam int WIN_HI = ADDR_W - 1;
  localparam int WIN_LO = ADDR_W - 8;

  logic hitNow;
  logic selQ;

  assign hitNow = (addrIn[WIN_HI:WIN_LO] == BASE);

  // select and ready terms settle into flops before reaching the output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      selQ   <= selIn & hitNow;
      readyQ <= regionReady;
    end
  end

  // single mux level fed only by flops
  assign readyOut = selQ ? readyQ : 1'b1;

  always_comb begin
    strobes.inWindow = hitNow;
    strobes.wordIdx  = addrIn[WORD_IDX_W+1:2];
    strobes.rdLoad   = selIn & enableIn;
    strobes.wrEn     = selIn & enableIn & writeIn & readyOut & hitNow;
  end

endmodule

// File: rtl/apb_bank_dp.sv
module apb_bank_dp
  import apb_bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic [DATA_W-1:0] wdataIn,
  output logic [DATA_W-1:0] rdataOut
);

  localparam int MAX_WORDS = 1 << WORD_IDX_W;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] muxVal;
  logic [DATA_W-1:0] rdataQ;

  // one enable-gated word per mapped offset
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[g] <= '0;
      end else if (strobes.wrEn && (strobes.wordIdx == WORD_IDX_W'(g))) begin
        regFile[g] <= wdataIn;
      end
    end
  end

  // read mux; unmapped offsets and misses fall through to zero
  always_comb begin
    muxVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobes.inWindow && (strobes.wordIdx == WORD_IDX_W'(i))) begin
        muxVal = regFile[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobes.rdLoad) begin
      rdataQ <= muxVal;
    end
  end

  assign rdataOut = rdataQ;

  initial begin
    if (NUM_REGS < 1 || NUM_REGS > MAX_WORDS) begin
      $error("NUM_REGS out of range");
    end
  end

endmodule

// File: rtl/apb_reg_bank.sv
module apb_reg_bank
  import apb_bank_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 32,
  parameter int         NUM_REGS = 40,
  parameter logic [7:0] BASE     = 8'hA5
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              selIn,
  input  logic              enableIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic              regionReady,
  output logic [DATA_W-1:0] rdataOut,
  output logic              readyOut
);

  bankStrobes_t strobes;
  logic         readyQ;

  apb_bank_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE)) u_ctrl (
    .clk        (busClk),
    .rstN       (busRstN),
    .selIn      (selIn),
    .enableIn   (enableIn),
    .writeIn    (writeIn),
    .addrIn     (addrIn),
    .regionReady(regionReady),
    .readyOut   (readyOut),
    .readyQ     (readyQ),
    .strobes    (strobes)
  );

  apb_bank_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk     (busClk),
    .rstN    (busRstN),
    .strobes (strobes),
    .wdataIn (wdataIn),
    .rdataOut(rdataOut)
  );

endmodule

// File: rtl/apb_reg_bank_chk.sv
module apb_reg_bank_chk #(
  parameter int         ADDR_W = 16,
  parameter int         DATA_W = 32,
  parameter logic [7:0] BASE   = 8'hA5
) (
  input logic              busClk,
  input logic              busRstN,
  input logic              selIn,
  input logic              enableIn,
  input logic [ADDR_W-1:0] addrIn,
  input logic              regionReady,
  input logic [DATA_W-1:0] rdataOut,
  input logic              readyOut,
  input logic              readyQ
);

  logic hit;
  assign hit = (addrIn[ADDR_W-1:ADDR_W-8] == BASE);

  // R1
  always @(posedge busClk) begin
    if (!busRstN) begin
      reset_state_chk: assert (readyOut && rdataOut == '0)
        else $error("reset state wrong");
    end
  end

  // R2
  win_ready_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (selIn && hit) |=> (readyOut == $past(regionReady)));

  // R3
  miss_ready_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (!selIn || !hit) |=> readyOut);

  // R4
  ready_known_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (selIn && enableIn) |-> !$isunknown(readyOut));

  // R5
  complete_ready_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (selIn && enableIn && readyOut && hit) |-> readyQ);

  // R6
  rdata_hold_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    !(selIn && enableIn) |=> $stable(rdataOut));

endmodule

bind apb_reg_bank apb_reg_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_chk (
  .busClk     (busClk),
  .busRstN    (busRstN),
  .selIn      (selIn),
  .enableIn   (enableIn),
  .addrIn     (addrIn),
  .regionReady(regionReady),
  .rdataOut   (rdataOut),
  .readyOut   (readyOut),
  .readyQ     (readyQ)
);

// File: tb/tb_apb_reg_bank.sv
module tb_apb_reg_bank;

  localparam int         NUM_REGS = 40;
  localparam logic [7:0] BASE     = 8'hA5;

  logic        busClk = 1'b0;
  logic        busRstN = 1'b0;
  logic        selIn = 1'b0, enableIn = 1'b0, writeIn = 1'b0;
  logic [15:0] addrIn = '0;
  logic [31:0] wdataIn = '0;
  logic        regionReady = 1'b0;
  logic [31:0] rdataOut;
  logic        readyOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [64];

  apb_reg_bank #(.NUM_REGS(NUM_REGS), .BASE(BASE)) dut (
    .busClk(busClk), .busRstN(busRstN), .selIn(selIn), .enableIn(enableIn),
    .writeIn(writeIn), .addrIn(addrIn), .wdataIn(wdataIn),
    .regionReady(regionReady), .rdataOut(rdataOut), .readyOut(readyOut)
  );

  always #2 busClk = ~busClk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkAddr(logic [7:0] win, int idx, int lo);
    return {win, 6'(idx), 2'(lo)};
  endfunction

  // full transfer; waits = extra access cycles before completion (in window)
  task automatic xfer(logic wr, logic [15:0] a, logic [31:0] d, int waits,
                      output logic [31:0] rd);
    logic inWin;
    inWin = (a[15:8] == BASE);
    @(negedge busClk);
    selIn = 1'b1; enableIn = 1'b0; writeIn = wr; addrIn = a; wdataIn = d;
    regionReady = (waits == 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge busClk);
      enableIn = 1'b1;
      regionReady = (i + 1 >= waits);
      // R2 / R3: ready in access cycle i
      check(inWin ? "R2 ready in window" : "R3 ready outside window",
            {31'b0, readyOut}, {31'b0, (!inWin || i >= waits)});
      if (readyOut === 1'b1) break;
    end
    @(negedge busClk);
    selIn = 1'b0; enableIn = 1'b0; writeIn = 1'b0; regionReady = 1'b0;
    rd = rdataOut;
  endtask

  function automatic logic [31:0] expRead(logic [15:0] a);
    int idx;
    idx = int'(a[7:2]);
    return (a[15:8] == BASE && idx < NUM_REGS) ? model[idx] : 32'h0;
  endfunction

  initial begin
    repeat (50000) @(posedge busClk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    logic [15:0] a;
    for (int i = 0; i < 64; i++) model[i] = '0;

    repeat (3) @(negedge busClk);
    // R1: state during reset
    check("R1 ready in reset", {31'b0, readyOut}, 32'h1);
    check("R1 rdata in reset", rdataOut, 32'h0);
    busRstN = 1'b1;
    @(negedge busClk);
    check("R1 ready after reset", {31'b0, readyOut}, 32'h1);

    // R1: every word reads zero after reset
    for (int i = 0; i < 64; i++) begin
      a = mkAddr(BASE, i, 0);
      xfer(1'b0, a, '0, 1, rd);
      check("R1 register zero", rd, 32'h0);
    end

    // R8 / R9: write every index with varied wait counts
    for (int i = 0; i < 64; i++) begin
      logic [31:0] v;
      v = (32'h9E37_79B9 * (i + 1)) ^ {i[7:0], 24'h5A3C0F};
      a = mkAddr(BASE, i, i % 4);
      xfer(1'b1, a, v, i % 4, rd);
      if (i < NUM_REGS) model[i] = v;
    end

    // R7: reads ordered to flip many address bits, varied waits and low bits
    for (int i = 0; i < 64; i++) begin
      int idx;
      idx = (i % 2 == 0) ? (i / 2) : (63 - i / 2);
      a = mkAddr(BASE, idx, (i * 3) % 4);
      xfer(1'b0, a, '0, (i % 3) + 1, rd);
      check("R7 R8 R9 read matches model", rd, expRead(a));
    end

    // R3 / R7 / R9: accesses outside the window
    for (int k = 0; k < 8; k++) begin
      logic [7:0] win;
      win = BASE ^ (8'h01 << k);
      a = mkAddr(win, k, 0);
      xfer(1'b1, a, 32'hDEAD_0000 + k, 2, rd);
      xfer(1'b0, a, '0, 2, rd);
      check("R7 miss reads zero", rd, 32'h0);
      a = mkAddr(BASE, k, 0);
      xfer(1'b0, a, '0, 1, rd);
      check("R9 miss write ignored", rd, model[k]);
    end

    // R8: access-phase edge with ready low commits nothing (aborted write)
    @(negedge busClk);
    selIn = 1'b1; enableIn = 1'b0; writeIn = 1'b1;
    addrIn = mkAddr(BASE, 5, 0); wdataIn = 32'h1234_5678; regionReady = 1'b0;
    @(negedge busClk);
    enableIn = 1'b1;
    check("R8 ready low in wait", {31'b0, readyOut}, 32'h0);
    @(negedge busClk);
    selIn = 1'b0; enableIn = 1'b0; writeIn = 1'b0;
    @(negedge busClk);
    xfer(1'b0, mkAddr(BASE, 5, 0), '0, 1, rd);
    check("R8 stalled write ignored", rd, model[5]);

    // R6: read data holds while idle and during setup phases
    held = rdataOut;
    @(negedge busClk);
    selIn = 1'b1; addrIn = mkAddr(BASE, 7, 0);
    @(negedge busClk);
    check("R6 hold in setup", rdataOut, held);
    selIn = 1'b0;
    repeat (3) @(negedge busClk);
    check("R6 hold idle", rdataOut, held);

    // R1: reset mid-run clears registers
    busRstN = 1'b0;
    @(negedge busClk);
    check("R1 rdata cleared", rdataOut, 32'h0);
    busRstN = 1'b1;
    for (int i = 0; i < 64; i++) model[i] = '0;
    xfer(1'b0, mkAddr(BASE, 3, 0), '0, 1, rd);
    check("R1 register cleared", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule